// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 32 primary interrupt inputs and 32 secondary peripheral inputs into one CPU interrupt line with an encoded vector. Each input has its own capture style, fixed at build time: an edge-captured bit latches on a rising edge of its synchronized input and holds until software clears it. A level-sensitive bit follows its synchronized input. Both levels have a status register and a mask register. These four registers sit behind a simple synchronous register port: writes take effect at the clock edge, and reads are combinational from the address.

The secondary inputs fall into three contiguous groups. Each group drives one summary bit of the primary status. The summary bit is set when any bit of its group is both set and unmasked at the secondary level. The primary mask then gates the summary bit again. Software reads the vector to find which source to service. The vector names the lowest pending unmasked primary bit. If that bit is a summary bit, the vector descends to the lowest pending unmasked secondary bit of its group.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, all four registers read zero, and `cpu_irq` and `vec_valid` are low.
- R2: Primary level-sensitive bits are 0-3, 7-15, 20, 21 and 25-27. Each reads as its input after two register stages, and a write to the primary status register does not change them.
- R3: Primary edge bits are 16-19, 22-24 and 28-31. Each sets on a rising edge of its synchronized input and stays set after the input falls.
- R4: Writing the status register (primary at address 0, secondary at address 2) clears each edge bit whose data bit is 0 and leaves it unchanged where the data bit is 1. A rising edge in the same cycle as the clear wins.
- R5: Secondary bits 16, 22 and 28 are edge-captured with the same set and clear rules. All other secondary bits are level-sensitive.
- R6: Primary status bit 4 is the OR of secondary bits 16-31 ANDed with the secondary mask. Bit 5 is the same for bits 8-15, and bit 6 for bits 0-7. The direct primary inputs 4-6 have no effect.
- R7: When the primary status ANDed with the primary mask is nonzero, `cpu_irq` and `vec_valid` are high. If the lowest set bit of that AND is not a summary bit, `vec_id` equals its index (0-31).
- R8: When the lowest pending unmasked primary bit is a summary bit, `vec_id` is 32 plus the index of the lowest bit of that group in the secondary status ANDed with the secondary mask.
- R9: When the primary status ANDed with the primary mask is zero, `cpu_irq` and `vec_valid` are low, even if unmasked secondary bits are pending.
- R10: The primary mask (address 1) and the secondary mask (address 3) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_src | input | 32 | Raw primary interrupt inputs (bits 4-6 unused) |
| sec_src | input | 32 | Raw secondary peripheral interrupt inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 primary status, 1 primary mask, 2 secondary status, 3 secondary mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cpu_irq | output | 1 | CPU interrupt request |
| vec_valid | output | 1 | `vec_id` names a pending source |
| vec_id | output | 7 | 0-31 primary source, 32-63 secondary source |

## Verification
The assertions check on every cycle that latched edge bits at both levels hold unless their status register is written. They also check that a reported vector always names a bit that is set and unmasked, and that no lower unmasked primary bit is pending. A further check is that no vector or request appears while the masked primary status is zero. The bench scenarios show the rest. These are the two-stage input latency, the write-zero-to-clear rule, the fact that level bits and the direct summary inputs cannot be written or driven, the mapping of the three groups onto the summary bits, and the descent to the lowest bit within the winning group.

// File: rtl/cirq_pkg.sv
// Package: shared register map, capture-style masks and grouping of the
// cascaded interrupt controller. Assumes 32 sources per level.
package cirq_pkg;
    localparam int unsigned SRC_W = 32;
    localparam int unsigned IDX_W = 5;

    typedef enum logic [1:0] {
        REG_PSTAT = 2'd0,
        REG_PMASK = 2'd1,
        REG_SSTAT = 2'd2,
        REG_SMASK = 2'd3
    } reg_addr_e;

    // Capture style per bit: 1 = edge-latched, 0 = level-following
    localparam logic [SRC_W-1:0] PRI_EDGE_BITS = 32'hF1CF_0000;
    localparam logic [SRC_W-1:0] SEC_EDGE_BITS = 32'h1041_0000;

    // Primary positions carrying secondary-group summaries
    localparam int unsigned SUM_SERPAR = 4;
    localparam int unsigned SUM_MISC   = 5;
    localparam int unsigned SUM_AUDIO  = 6;
    localparam logic [SRC_W-1:0] SUM_BITS = 32'h0000_0070;

    // Secondary group membership
    localparam logic [SRC_W-1:0] GRP_AUDIO  = 32'h0000_00FF;
    localparam logic [SRC_W-1:0] GRP_MISC   = 32'h0000_FF00;
    localparam logic [SRC_W-1:0] GRP_SERPAR = 32'hFFFF_0000;

    // Secondary group mask selected by a primary summary position
    function automatic logic [SRC_W-1:0] group_of(input logic [IDX_W-1:0] pos);
        case (pos)
            IDX_W'(SUM_SERPAR): group_of = GRP_SERPAR;
            IDX_W'(SUM_MISC):   group_of = GRP_MISC;
            IDX_W'(SUM_AUDIO):  group_of = GRP_AUDIO;
            default:            group_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_sync_capture.sv
// Module: irq_sync_capture
// Synchronizes N raw inputs and turns each into a status bit. A bit is
// either edge-latched (set on synchronized rise, cleared by a write of 0)
// or level-following, chosen per bit by EDGE_MASK. Assumes that raw inputs
// are asynchronous or quasi-static. A set event beats a clear in the same cycle.
module irq_sync_capture #(
    parameter int unsigned      N           = 32,
    parameter logic [N-1:0]     EDGE_MASK   = '0,
    parameter int unsigned      SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic         clr_en,
    input  logic [N-1:0] clr_val,
    output logic [N-1:0] status
);
    logic [N-1:0] sync_q [SYNC_STAGES];
    logic [N-1:0] hist_q;
    logic [N-1:0] synced;

    // Synchronizer chain for all inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(SYNC_STAGES); s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= raw;
            for (int s = 1; s < int'(SYNC_STAGES); s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // Previous synchronized value for rise detection
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= synced;
    end

    for (genvar i = 0; i < int'(N); i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic latch_q;
            // Edge latch: rise sets, software write of 0 clears, set wins
            always_ff @(posedge clk) begin
                if (!rst_n)                        latch_q <= 1'b0;
                else if (synced[i] && !hist_q[i])  latch_q <= 1'b1;
                else if (clr_en && !clr_val[i])    latch_q <= 1'b0;
            end
            assign status[i] = latch_q;
        end else begin : g_level
            assign status[i] = synced[i];
        end
    end
endmodule

// File: rtl/irq_lowest_pick.sv
// Module: irq_lowest_pick
// Finds the lowest set bit of a request vector. Purely combinational.
module irq_lowest_pick #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module: cascade_irq_ctrl
// Two-level interrupt controller. A secondary 32-input controller feeds
// three group summaries into primary bits 4-6. The block drives one CPU
// request and a vector for the lowest pending unmasked source, descending
// into the secondary level when a summary wins. Register port: synchronous
// writes, combinational reads.
module cascade_irq_ctrl #(
    parameter int unsigned SRC_W       = 32,
    parameter int unsigned VEC_W       = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] pri_src,
    input  logic [SRC_W-1:0] sec_src,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [SRC_W-1:0] reg_wdata,
    output logic [SRC_W-1:0] reg_rdata,
    output logic             cpu_irq,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_id
);
    import cirq_pkg::*;

    localparam int unsigned IW = $clog2(SRC_W);

    logic [SRC_W-1:0] pri_cap, pri_status, pri_mask_q, pri_pend;
    logic [SRC_W-1:0] sec_status, sec_mask_q, sec_pend, sec_sel;
    logic             wr_pstat, wr_sstat;
    logic             p_found, s_found, p_is_sum;
    logic [IW-1:0]    p_idx, s_idx;

    assign wr_pstat = reg_we && (reg_addr == REG_PSTAT);
    assign wr_sstat = reg_we && (reg_addr == REG_SSTAT);

    irq_sync_capture #(
        .N(SRC_W), .EDGE_MASK(PRI_EDGE_BITS), .SYNC_STAGES(SYNC_STAGES)
    ) u_pri_cap (
        .clk(clk), .rst_n(rst_n), .raw(pri_src & ~SUM_BITS),
        .clr_en(wr_pstat), .clr_val(reg_wdata), .status(pri_cap)
    );

    irq_sync_capture #(
        .N(SRC_W), .EDGE_MASK(SEC_EDGE_BITS), .SYNC_STAGES(SYNC_STAGES)
    ) u_sec_cap (
        .clk(clk), .rst_n(rst_n), .raw(sec_src),
        .clr_en(wr_sstat), .clr_val(reg_wdata), .status(sec_status)
    );

    // Mask registers, written through the register port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_mask_q <= '0;
            sec_mask_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == REG_PMASK) pri_mask_q <= reg_wdata;
            if (reg_addr == REG_SMASK) sec_mask_q <= reg_wdata;
        end
    end

    assign sec_pend = sec_status & sec_mask_q;

    // Merge group summaries into the primary status image
    always_comb begin
        pri_status             = pri_cap & ~SUM_BITS;
        pri_status[SUM_SERPAR] = |(sec_pend & GRP_SERPAR);
        pri_status[SUM_MISC]   = |(sec_pend & GRP_MISC);
        pri_status[SUM_AUDIO]  = |(sec_pend & GRP_AUDIO);
    end

    assign pri_pend = pri_status & pri_mask_q;

    // Register read multiplexer
    always_comb begin
        case (reg_addr)
            REG_PSTAT: reg_rdata = pri_status;
            REG_PMASK: reg_rdata = pri_mask_q;
            REG_SSTAT: reg_rdata = sec_status;
            default:   reg_rdata = sec_mask_q;
        endcase
    end

    irq_lowest_pick #(.N(SRC_W), .IW(IW)) u_pri_pick (
        .req(pri_pend), .found(p_found), .idx(p_idx)
    );

    assign p_is_sum = SUM_BITS[p_idx];
    assign sec_sel  = sec_pend & group_of(p_idx);

    irq_lowest_pick #(.N(SRC_W), .IW(IW)) u_sec_pick (
        .req(sec_sel), .found(s_found), .idx(s_idx)
    );

    // Vector encode: primary index, or offset secondary index on a summary win
    always_comb begin
        if (p_is_sum && s_found) vec_id = VEC_W'(SRC_W) + VEC_W'(s_idx);
        else                     vec_id = VEC_W'(p_idx);
    end

    assign vec_valid = p_found;
    assign cpu_irq   = p_found;
endmodule

// File: rtl/cascade_irq_ctrl_checker.sv
// Module: cascade_irq_ctrl_checker
// Cycle-by-cycle properties of the cascaded interrupt controller, bound
// into the top module. Observes status, mask and vector state only.
module cascade_irq_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] pri_status,
    input logic [31:0] pri_mask_q,
    input logic [31:0] sec_status,
    input logic [31:0] sec_mask_q,
    input logic        cpu_irq,
    input logic        vec_valid,
    input logic [6:0]  vec_id
);
    import cirq_pkg::*;

    AST_PRI_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == REG_PSTAT) |=> ((pri_status & $past(pri_status) & PRI_EDGE_BITS) == ($past(pri_status) & PRI_EDGE_BITS))); // R3
    AST_SEC_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == REG_SSTAT) |=> ((sec_status & $past(sec_status) & SEC_EDGE_BITS) == ($past(sec_status) & SEC_EDGE_BITS))); // R5
    AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pri_status & pri_mask_q) == '0) |-> (!vec_valid && !cpu_irq)); // R9
    AST_PRI_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_id[5]) |-> (pri_status[vec_id[4:0]] && pri_mask_q[vec_id[4:0]] && !SUM_BITS[vec_id[4:0]])); // R7
    AST_PRI_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_id[5]) |-> ((pri_status & pri_mask_q & ((32'd1 << vec_id[4:0]) - 32'd1)) == '0)); // R7
    AST_SEC_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_id[5]) |-> (sec_status[vec_id[4:0]] && sec_mask_q[vec_id[4:0]])); // R8
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_id < 7'd64)); // R8
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_checker u_checker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .pri_status(pri_status), .pri_mask_q(pri_mask_q),
    .sec_status(sec_status), .sec_mask_q(sec_mask_q),
    .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_id(vec_id)
);

// File: tb/cascade_irq_ctrl_bench.sv
// Directed bench for cascade_irq_ctrl: one task per scenario.
module cascade_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pri_src = '0;
    logic [31:0] sec_src = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq, vec_valid;
    logic [6:0]  vec_id;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cascade_irq_ctrl u_cascade_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pri_src(pri_src), .sec_src(sec_src),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .vec_valid(vec_valid),
        .vec_id(vec_id)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_vec(input string tag, input logic v, input logic [6:0] id);
        @(negedge clk);
        chk({tag, " valid"}, {31'd0, vec_valid}, {31'd0, v});
        chk({tag, " irq"}, {31'd0, cpu_irq}, {31'd0, v});
        if (v) chk({tag, " id"}, {25'd0, vec_id}, {25'd0, id});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), d);
            chk("R1 reg reset", d, 32'h0);
        end
        chk_vec("R1 outputs", 1'b0, 7'd0);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        reg_write(2'd1, 32'hA5A5_0F0F);
        reg_write(2'd3, 32'h1234_5678);
        reg_read(2'd1, d); chk("R10 pri mask", d, 32'hA5A5_0F0F);
        reg_read(2'd3, d); chk("R10 sec mask", d, 32'h1234_5678);
        reg_write(2'd1, 32'h0);
        reg_write(2'd3, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        reg_write(2'd1, 32'h0000_0004);
        @(negedge clk); pri_src = 32'h0000_0004;
        settle(4);
        reg_read(2'd0, d); chk("R2 level follows", d, 32'h0000_0004);
        chk_vec("R7 level vec", 1'b1, 7'd2);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, d); chk("R2 write ignored", d, 32'h0000_0004);
        @(negedge clk); pri_src = '0;
        settle(4);
        reg_read(2'd0, d); chk("R2 level drops", d, 32'h0);
        chk_vec("R9 idle", 1'b0, 7'd0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        reg_write(2'd1, 32'h0002_0000);
        @(negedge clk); pri_src = 32'h0002_0000;
        settle(3);
        pri_src = '0;
        settle(4);
        reg_read(2'd0, d); chk("R3 edge latched", d, 32'h0002_0000);
        chk_vec("R7 edge vec", 1'b1, 7'd17);
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, d); chk("R4 write one keeps", d, 32'h0002_0000);
        reg_write(2'd0, ~32'h0002_0000);
        reg_read(2'd0, d); chk("R4 write zero clears", d, 32'h0);
        reg_write(2'd1, 32'h0);
    endtask

    task automatic t_priority();
        @(negedge clk); pri_src = 32'h0000_0208;
        settle(4);
        reg_write(2'd1, 32'h0000_0208);
        chk_vec("R7 lowest wins", 1'b1, 7'd3);
        reg_write(2'd1, 32'h0000_0200);
        chk_vec("R7 masked low", 1'b1, 7'd9);
        reg_write(2'd1, 32'h0);
        chk_vec("R9 all masked", 1'b0, 7'd0);
        @(negedge clk); pri_src = '0;
        settle(4);
    endtask

    task automatic t_cascade();
        logic [31:0] d;
        @(negedge clk); sec_src = 32'h0000_0408;
        settle(4);
        reg_write(2'd3, 32'h0000_0408);
        reg_write(2'd1, 32'h0000_0060);
        reg_read(2'd0, d); chk("R6 summaries", d, 32'h0000_0060);
        chk_vec("R8 misc group", 1'b1, 7'd42);
        reg_write(2'd1, 32'h0000_0040);
        chk_vec("R8 audio group", 1'b1, 7'd35);
        @(negedge clk); pri_src = 32'h0000_0074;
        settle(4);
        reg_read(2'd0, d); chk("R6 direct ignored", d, 32'h0000_0064);
        reg_write(2'd1, 32'h0000_0044);
        chk_vec("R7 primary below summary", 1'b1, 7'd2);
        @(negedge clk); pri_src = '0;
        settle(4);
        reg_write(2'd3, 32'h0);
        reg_read(2'd0, d); chk("R6 sec masked", d, 32'h0);
        reg_write(2'd1, 32'h0000_0070);
        chk_vec("R9 secondary masked", 1'b0, 7'd0);
        @(negedge clk); sec_src = '0;
        settle(4);
    endtask

    task automatic t_sec_edge();
        logic [31:0] d;
        @(negedge clk); sec_src = 32'h1080_0000 | 32'h0040_0000;
        settle(3);
        sec_src = '0;
        settle(4);
        reg_read(2'd2, d); chk("R5 sec edges", d, 32'h1040_0000);
        reg_write(2'd3, 32'h1040_0000);
        reg_write(2'd1, 32'h0000_0010);
        chk_vec("R8 serpar group", 1'b1, 7'd54);
        reg_write(2'd2, ~32'h0040_0000);
        reg_read(2'd2, d); chk("R4 sec clear", d, 32'h1000_0000);
        chk_vec("R8 next in group", 1'b1, 7'd60);
        reg_write(2'd2, 32'h0);
        chk_vec("R9 cleared", 1'b0, 7'd0);
        reg_write(2'd1, 32'h0);
        reg_write(2'd3, 32'h0);
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_masks();
        t_level();
        t_edge();
        t_priority();
        t_cascade();
        t_sec_edge();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule